// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog and interval timer built around an 8-bit up-counter. A power-of-two prescaler drives the counter, and software picks one of eight division ratios. Software reaches the block through a small register bus with two locations: the count itself and a control/status byte.

Every write is 16 bits wide. A write changes state only if its upper byte holds the key that belongs to the addressed location. This guards the timer against stray writes from a program that has lost control.

When the counter wraps from its maximum back to zero, the block sets a sticky overflow flag. Depending on the mode bit, it then either holds a reset request high for a fixed number of cycles or gives a one-cycle interrupt pulse. Reads are combinational and return one byte.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 0 whose data bits 15:8 equal 0x5A loads data bits 7:0 into the counter at that clock edge.
- R2: A write to address 1 whose data bits 15:8 equal 0xA5 updates the control byte, which has this layout:
  - bit 7 is enable;
  - bit 6 is mode (1 = watchdog, 0 = interval);
  - bit 5 is the overflow flag;
  - bits 2:0 are the clock-select code;
  - bits 4:3 are not stored and read as 0.
- R3: A write to either address whose upper byte differs from that address's key changes no register bit.
- R4: After reset the counter and the control byte read 0x00, and both the reset-request and interrupt outputs are low.
- R5: With clock-select code n and the timer enabled, the counter steps by one every 32·2^n clock cycles. The first step comes exactly 32·2^n cycles after the edge that sets enable from a disabled state.
- R6: While enable is 0 the counter holds its value and the prescaler is held at zero.
- R7: The overflow flag is set at the edge where the counter wraps from 0xFF to 0x00 and then stays set. A keyed control write with bit 5 = 0 clears it, and a write with bit 5 = 1 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: In interval mode a wrap raises the interrupt output for exactly one cycle, starting at the wrap edge, and the reset-request output stays low.
- R9: In watchdog mode a wrap raises the reset-request output for exactly 16 cycles, starting at the wrap edge, and the interrupt output stays low.
- R10: The read data is combinational: address 0 returns the counter and address 1 returns the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 counter, 1 control |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data: key in 15:8, value in 7:0 |
| bus_rdata | output | 8 | Read data for the selected register |
| wdt_rst_o | output | 1 | Reset request, watchdog mode |
| wdt_irq_o | output | 1 | Interrupt pulse, interval mode |

## Verification
The assertions assume that the bus strobe is held for a single cycle per write and that the inputs are stable around each clock edge. The bench meets this by driving the bus only on falling edges and dropping the strobe after one rising edge.

The pulse-shape assertions also assume that two wraps never come closer together than the shortest prescaler period of 32 cycles. That holds for any bus traffic, because every counter step waits for a prescaler tick. The bench keeps the inputs legal by changing the enable bit only through disable-then-enable sequences.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic             en;
        logic             wd_mode;
        logic             ovf;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int BASE_SHIFT = 5,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int PRE_W   = BASE_SHIFT + MAX_SEL;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;
    logic [SEL_W-1:0] shamt;

    always_comb begin
        shamt = SEL_W'(MAX_SEL) - sel;
        mask  = {PRE_W{1'b1}} >> shamt;
        tick  = en && ((pre_q & mask) == mask);
        pre_d = en ? pre_q + PRE_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdt_pulse_hold.sv
module wdt_pulse_hold #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        if (start)              left_d = CW'(LEN);
        else if (left_q != '0)  left_d = left_q - CW'(1);
        else                    left_d = left_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int         CNT_W      = 8,
    parameter logic [7:0] KEY_CNT    = 8'h5A,
    parameter logic [7:0] KEY_CTRL   = 8'hA5,
    parameter int         BASE_SHIFT = 5,
    parameter int         RST_LEN    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_addr,
    input  logic               bus_we,
    input  logic [2*CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               wdt_rst_o,
    output logic               wdt_irq_o
);
    import wdt_pkg::*;

    localparam int PAD_W = CNT_W - 3 - SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             irq;
    } state_t;

    state_t state_d, state_q;
    logic   tick, wrap, wr_cnt, wr_ctrl, rst_start;
    logic [CNT_W-1:0] wlow;

    wdt_prescaler #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q.ctrl.en),
        .sel  (state_q.ctrl.sel),
        .tick (tick)
    );

    always_comb begin
        state_d = state_q;
        wlow    = bus_wdata[CNT_W-1:0];
        wr_cnt  = bus_we && !bus_addr && (bus_wdata[2*CNT_W-1 -: 8] == KEY_CNT);
        wr_ctrl = bus_we &&  bus_addr && (bus_wdata[2*CNT_W-1 -: 8] == KEY_CTRL);
        wrap    = 1'b0;

        if (wr_cnt) begin
            state_d.cnt = wlow;
        end else if (tick) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
            wrap        = (state_q.cnt == {CNT_W{1'b1}});
        end

        if (wr_ctrl) begin
            state_d.ctrl.en      = wlow[CNT_W-1];
            state_d.ctrl.wd_mode = wlow[CNT_W-2];
            state_d.ctrl.ovf     = state_q.ctrl.ovf & wlow[CNT_W-3];
            state_d.ctrl.sel     = wlow[SEL_W-1:0];
        end
        if (wrap) state_d.ctrl.ovf = 1'b1;

        state_d.irq = wrap && !state_q.ctrl.wd_mode;
        rst_start   = wrap &&  state_q.ctrl.wd_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    wdt_pulse_hold #(.LEN(RST_LEN)) i_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .start(rst_start),
        .pulse(wdt_rst_o)
    );

    assign wdt_irq_o = state_q.irq;
    assign bus_rdata = bus_addr
        ? {state_q.ctrl.en, state_q.ctrl.wd_mode, state_q.ctrl.ovf, {PAD_W{1'b0}}, state_q.ctrl.sel}
        : state_q.cnt;

    logic [CNT_W-1:0] cnt_now;
    logic             en_now, mode_now, ovf_now;
    assign cnt_now  = state_q.cnt;
    assign en_now   = state_q.ctrl.en;
    assign mode_now = state_q.ctrl.wd_mode;
    assign ovf_now  = state_q.ctrl.ovf;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int         CNT_W    = 8,
    parameter logic [7:0] KEY_CNT  = 8'h5A,
    parameter logic [7:0] KEY_CTRL = 8'hA5,
    parameter int         RST_LEN  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_addr,
    input logic               bus_we,
    input logic [2*CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]   cnt_now,
    input logic               en_now,
    input logic               mode_now,
    input logic               ovf_now,
    input logic               wdt_rst_o,
    input logic               wdt_irq_o
);
    localparam int HW = $clog2(RST_LEN + 2);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (wdt_rst_o) hi_cnt <= hi_cnt + HW'(1);
        else                hi_cnt <= '0;
    end

    logic good_cnt_wr, clr_wr;
    assign good_cnt_wr = bus_we && !bus_addr && (bus_wdata[2*CNT_W-1 -: 8] == KEY_CNT);
    assign clr_wr      = bus_we &&  bus_addr && (bus_wdata[2*CNT_W-1 -: 8] == KEY_CTRL)
                         && !bus_wdata[CNT_W-3];

    // R6, R3: disabled counter without a keyed counter write stays put
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_now && !good_cnt_wr) |=> $stable(cnt_now));

    // R7: flag only drops through a keyed clearing write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_now && !clr_wr) |=> ovf_now);

    a_r7_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wdt_rst_o) || wdt_irq_o) |-> ovf_now);

    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_o |=> !wdt_irq_o);

    a_r8_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_o |-> !$past(mode_now));

    a_r9_rst_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> $past(mode_now));

    a_r9_rst_max: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (hi_cnt < HW'(RST_LEN)));

    a_r9_rst_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_LEN)));
endmodule

bind keyed_wdt wdt_checker #(
    .CNT_W(CNT_W), .KEY_CNT(KEY_CNT), .KEY_CTRL(KEY_CTRL), .RST_LEN(RST_LEN)
) i_wdt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .cnt_now  (cnt_now),
    .en_now   (en_now),
    .mode_now (mode_now),
    .ovf_now  (ovf_now),
    .wdt_rst_o(wdt_rst_o),
    .wdt_irq_o(wdt_irq_o)
);

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        wdt_rst_o, wdt_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_wdt i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    // {addr, wdata, expected counter, expected control}; enable stays 0
    localparam logic [32:0] VEC [0:7] = '{
        {1'b0, 16'h5A37, 8'h37, 8'h00},
        {1'b0, 16'hA599, 8'h37, 8'h00},
        {1'b1, 16'hA503, 8'h37, 8'h03},
        {1'b1, 16'h5AC7, 8'h37, 8'h03},
        {1'b1, 16'hA51C, 8'h37, 8'h04},
        {1'b1, 16'hA520, 8'h37, 8'h00},
        {1'b0, 16'h0055, 8'h37, 8'h00},
        {1'b0, 16'h5AFF, 8'hFF, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic period_test(input int s);
        logic [7:0] v;
        int p;
        p = 32 << s;
        bus_write(1'b1, 16'hA500 | 16'(s));
        bus_write(1'b0, 16'h5A00);
        bus_write(1'b1, 16'hA580 | 16'(s));
        repeat (p - 1) @(posedge clk);
        @(negedge clk);
        rd(1'b0, v); check($sformatf("R5 sel%0d before step", s), 16'(v), 16'h00);
        @(posedge clk); @(negedge clk);
        rd(1'b0, v); check($sformatf("R5 sel%0d first step", s), 16'(v), 16'h01);
        repeat (p) @(posedge clk);
        @(negedge clk);
        rd(1'b0, v); check($sformatf("R5 sel%0d second step", s), 16'(v), 16'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int hi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R4 reset state
        rd(1'b0, v); check("R4 counter", 16'(v), 16'h00);
        rd(1'b1, v); check("R4 control", 16'(v), 16'h00);
        check("R4 outputs", {14'h0, wdt_rst_o, wdt_irq_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R10 table
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][32], VEC[i][31:16]);
            rd(1'b0, v); check($sformatf("R1/R3 vec%0d counter", i), 16'(v), 16'(VEC[i][15:8]));
            rd(1'b1, v); check($sformatf("R2/R3 vec%0d control", i), 16'(v), 16'(VEC[i][7:0]));
        end

        // R6: disabled counter holds
        repeat (200) @(posedge clk);
        @(negedge clk);
        rd(1'b0, v); check("R6 hold while disabled", 16'(v), 16'hFF);

        // R5 with R6 prescaler clear on each re-enable
        period_test(0);
        period_test(2);
        period_test(7);

        // R8 interval-mode wrap
        bus_write(1'b1, 16'hA500);
        bus_write(1'b0, 16'h5AFE);
        bus_write(1'b1, 16'hA580);
        repeat (63) @(posedge clk);
        @(negedge clk);
        check("R8 irq before wrap", 16'(wdt_irq_o), 16'h0);
        @(posedge clk); @(negedge clk);
        check("R8 irq at wrap", 16'(wdt_irq_o), 16'h1);
        check("R8 no reset request", 16'(wdt_rst_o), 16'h0);
        rd(1'b0, v); check("R8 counter wrapped", 16'(v), 16'h00);
        rd(1'b1, v); check("R7 flag set", 16'(v), 16'hA0);
        @(posedge clk); @(negedge clk);
        check("R8 irq one cycle", 16'(wdt_irq_o), 16'h0);

        // R7 flag write semantics
        bus_write(1'b1, 16'hA5A0);
        rd(1'b1, v); check("R7 write 1 keeps flag", 16'(v), 16'hA0);
        bus_write(1'b1, 16'h5A80);
        rd(1'b1, v); check("R7 bad key keeps flag", 16'(v), 16'hA0);
        bus_write(1'b1, 16'hA580);
        rd(1'b1, v); check("R7 write 0 clears flag", 16'(v), 16'h80);

        // R9 watchdog-mode wrap
        bus_write(1'b1, 16'hA500);
        bus_write(1'b0, 16'h5AFF);
        bus_write(1'b1, 16'hA5C0);
        repeat (31) @(posedge clk);
        @(negedge clk);
        check("R9 reset low before wrap", 16'(wdt_rst_o), 16'h0);
        @(posedge clk); @(negedge clk);
        check("R9 reset at wrap", 16'(wdt_rst_o), 16'h1);
        check("R9 no irq", 16'(wdt_irq_o), 16'h0);
        rd(1'b1, v); check("R9 control after wrap", 16'(v), 16'hE0);
        hi = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_o) hi++;
        end
        check("R9 reset length", 16'(hi), 16'd16);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule